// File: doc/BRIEF.md
# Call Duration Timer with Hold

This block times an answered telephone call. It runs from the 100 Hz system clock, divides it internally into a one-cycle tick once per second, and accumulates elapsed time as six BCD digits grouped into hours, minutes and seconds. The call controller sends a one-cycle start pulse when the far end answers. It sends a one-cycle stop pulse when either party hangs up.

While a call is in progress the live count is presented on the output and the running flag is high. On stop the count freezes, the running flag drops and the done flag rises, so the display logic can show the total length of the call until the next call starts. Digit multiplexing and segment decoding are handled elsewhere; this block only supplies the BCD digits and the two flags. Every register runs on the system clock, and the per-second tick acts as an enable. No divided clock is used.

Top module: `callDurationTimer`

## Requirements
- R1: A synchronous reset sets all six digits to 0 and clears both the running and done flags.
- R2: A start pulse sampled at a clock edge makes the outputs after that edge show all digits 0, running 1 and done 0. Start takes precedence over a stop in the same cycle.
- R3: While running, the seconds units digit advances once every TICK_DIV clocks. The first advance appears TICK_DIV edges after the start edge, and no change appears after TICK_DIV-1 edges.
- R4: The seconds units digit counts 0 to 9 and carries into the seconds tens digit, which counts 0 to 5. So 00:00:59 is followed by 00:01:00.
- R5: The minutes field has the same 0 to 59 structure and carries into the hours field. So 00:59:59 is followed by 01:00:00.
- R6: The hours field counts from 00 up to HOUR_TENS_MAX followed by 9, then wraps. At the top value, 00:00:00 follows. With the default, 99:59:59 wraps to 00:00:00.
- R7: A stop pulse while running clears running and sets done on the next edge. From then on the digits hold the final elapsed value unchanged.
- R8: Done stays high until the next start or reset. A stop pulse while not running has no effect on the digits or flags.
- R9: A start pulse while already running restarts the count at zero and also restarts the one-second prescaler. The next advance comes a full TICK_DIV clocks later.
- R10: elapsedBcd carries six 4-bit BCD digits, least significant first. Bits [3:0] hold the seconds units, [7:4] seconds tens, [11:8] minutes units, [15:12] minutes tens, [19:16] hours units and [23:20] hours tens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 100 Hz |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | One-cycle strobe: call answered |
| stopPulse | input | 1 | One-cycle strobe: call ended by either side |
| elapsedBcd | output | 24 | Six BCD digits hh:mm:ss, seconds units in bits [3:0] |
| running | output | 1 | High while a call is being timed |
| done | output | 1 | High after a call ended, until the next start or reset |

## Verification
On every cycle the assertions check several digit-level rules: each digit stays inside its own range, and it steps by one or wraps to zero only when enabled. Each digit also stays still without an enable and clears on start. The flag assertions check that running and done are never high together, that done persists, and that a stop while idle cannot raise done. Only the bench scenarios can show how these rules combine in time. These include the exact cycle of the first one-second advance after a start, the minute and hour carries, and the wrap at the top hour. The bench scenarios also cover the frozen total after a stop and the prescaler restart on a start mid-call.

// File: rtl/callTimerPkg.sv
package callTimerPkg;

  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 6;
  localparam int BCD_W      = DIGIT_W * NUM_DIGITS;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // restart the count at 00:00:00
    logic tickEn;    // advance the count by one second
  } timerCtlT;

endpackage

// File: rtl/bcdDigit.sv
module bcdDigit #(
  parameter int MAX_VAL = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       inc,
  output logic [3:0] val,
  output logic       carry
);

  localparam logic [3:0] TOP = 4'(MAX_VAL);

  logic atTop;
  assign atTop = (val == TOP);
  assign carry = inc && atTop;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      val <= '0;
    end else if (inc) begin
      val <= atTop ? '0 : val + 4'd1;
    end
  end

  // R4/R6: a digit never leaves its own range
  assert_digit_range_R4: assert property (@(posedge clk) disable iff (rst)
    val <= TOP);

  // R3: an enabled digit below its top steps by exactly one
  assert_digit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (inc && !clear && val < TOP) |=> (val == $past(val) + 4'd1));

  // R6: an enabled digit at its top wraps to zero
  assert_digit_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (inc && !clear && atTop) |=> (val == 4'd0));

  // R7: with no enable and no clear the digit holds
  assert_digit_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clear) |=> $stable(val));

  // R2: a clear zeroes the digit
  assert_digit_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clear |=> (val == 4'd0));

endmodule

// File: rtl/callTimerCtrl.sv
module callTimerCtrl
  import callTimerPkg::*;
#(
  parameter int TICK_DIV = 100
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     startPulse,
  input  logic     stopPulse,
  output timerCtlT ctl,
  output logic     running,
  output logic     done
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCount;
  logic             preLast;

  assign preLast = (preCount == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      done     <= 1'b0;
      preCount <= '0;
    end else if (startPulse) begin
      running  <= 1'b1;
      done     <= 1'b0;
      preCount <= '0;
    end else if (stopPulse && running) begin
      running  <= 1'b0;
      done     <= 1'b1;
      preCount <= '0;
    end else if (running) begin
      preCount <= preLast ? '0 : preCount + 1'b1;
    end
  end

  always_comb begin
    ctl.clearAll = startPulse;
    ctl.tickEn   = running && preLast && !startPulse;
  end

  // R3: prescaler stays inside its divide range
  assert_pre_range_R3: assert property (@(posedge clk) disable iff (rst)
    preCount <= PRE_LAST);

  // R2/R9: start always lands in running with a fresh prescaler
  assert_start_flags_R2: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> (running && !done && preCount == '0));

  // R7: stop while running ends the call
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (stopPulse && running && !startPulse) |=> (!running && done));

  // R7: the two flags are never high together
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(running && done));

  // R8: done persists until a start
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !startPulse) |=> done);

  // R8: stop while idle does not raise done
  assert_idle_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (!running && !done && !startPulse) |=> (!done && !running));

endmodule

// File: rtl/callTimerDatapath.sv
module callTimerDatapath
  import callTimerPkg::*;
#(
  parameter int HOUR_TENS_MAX = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  timerCtlT         ctl,
  output logic [BCD_W-1:0] digits
);

  // per-digit top value: seconds/minutes tens stop at 5, hours tens is set
  function automatic int digitMax(input int idx);
    if (idx == 1 || idx == 3) return 5;
    if (idx == NUM_DIGITS - 1) return HOUR_TENS_MAX;
    return 9;
  endfunction

  function automatic logic [BCD_W-1:0] topValue();
    logic [BCD_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      v[i*DIGIT_W +: DIGIT_W] = 4'(digitMax(i));
    end
    return v;
  endfunction

  localparam logic [BCD_W-1:0] TOP_ALL = topValue();

  logic [NUM_DIGITS:0]   incChain;
  logic [NUM_DIGITS-1:0] carryOut;

  assign incChain[0] = ctl.tickEn;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigit
    bcdDigit #(.MAX_VAL(digitMax(g))) i_digit (
      .clk   (clk),
      .rst   (rst),
      .clear (ctl.clearAll),
      .inc   (incChain[g]),
      .val   (digits[g*DIGIT_W +: DIGIT_W]),
      .carry (carryOut[g])
    );
    assign incChain[g+1] = carryOut[g];
  end

  // R6: the whole count wraps from its top value to zero
  assert_full_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.tickEn && !ctl.clearAll && digits == TOP_ALL) |=> (digits == '0));

  // R7: without a tick or clear the total is frozen
  assert_total_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctl.tickEn && !ctl.clearAll) |=> $stable(digits));

endmodule

// File: rtl/callDurationTimer.sv
module callDurationTimer
  import callTimerPkg::*;
#(
  parameter int TICK_DIV      = 100,
  parameter int HOUR_TENS_MAX = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startPulse,
  input  logic        stopPulse,
  output logic [23:0] elapsedBcd,
  output logic        running,
  output logic        done
);

  timerCtlT ctl;

  callTimerCtrl #(.TICK_DIV(TICK_DIV)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .ctl        (ctl),
    .running    (running),
    .done       (done)
  );

  callTimerDatapath #(.HOUR_TENS_MAX(HOUR_TENS_MAX)) i_datapath (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .digits (elapsedBcd)
  );

  // R1: reset leaves a clean idle display on the following cycle
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (elapsedBcd == '0 && !running && !done));

endmodule

// File: tb/test_callDurationTimer.sv
module test_callDurationTimer;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 3;
  localparam int HT_MAX     = 0;
  localparam int HMOD       = (HT_MAX + 1) * 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startPulse = 1'b0;
  logic        stopPulse = 1'b0;
  logic [23:0] elapsedBcd;
  logic        running;
  logic        done;

  int cyc = 0;
  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  typedef struct {
    int          at;
    logic [23:0] bcd;
    logic        run;
    logic        dn;
    string       tag;
  } expT;

  expT q[$];
  expT cur;

  callDurationTimer #(.TICK_DIV(TDIV), .HOUR_TENS_MAX(HT_MAX)) i_callDurationTimer (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .elapsedBcd (elapsedBcd),
    .running    (running),
    .done       (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] toBcd(input int secs);
    int h, m, s;
    h = (secs / 3600) % HMOD;
    m = (secs / 60) % 60;
    s = secs % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  // driver side: record what must be seen after edge c
  task automatic expectAt(input int c, input int secs, input bit run, input bit dn, input string tag);
    expT e;
    e.at = c; e.bcd = toBcd(secs); e.run = run; e.dn = dn; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pulseStart(input int e);
    while (cyc < e - 1) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic pulseStop(input int e);
    while (cyc < e - 1) @(negedge clk);
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
  endtask

  // monitor side: compare at the falling edge after the expected edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      cur = q.pop_front();
      nTests++;
      if (cur.at < cyc) begin
        nFail++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", cur.tag, cur.at, cyc);
      end else if (elapsedBcd !== cur.bcd || running !== cur.run || done !== cur.dn) begin
        nFail++;
        $display("FAIL %s @%0d: got bcd=%06h run=%0b done=%0b, expected bcd=%06h run=%0b done=%0b",
                 cur.tag, cyc, elapsedBcd, running, done, cur.bcd, cur.run, cur.dn);
      end
    end
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int s, t, u, s2, s3, r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expectAt(cyc + 1, 0, 0, 0, "R1 reset state");

    s = cyc + 3;
    expectAt(s,                0,     1, 0, "R2 start clears and runs");
    expectAt(s + TDIV - 1,     0,     1, 0, "R3 no advance before full period");
    expectAt(s + TDIV,         1,     1, 0, "R3 first second");
    expectAt(s + 9 * TDIV,     9,     1, 0, "R4 units at 9");
    expectAt(s + 10 * TDIV,    10,    1, 0, "R4 carry to seconds tens");
    expectAt(s + 59 * TDIV,    59,    1, 0, "R4 00:00:59");
    expectAt(s + 60 * TDIV,    60,    1, 0, "R4 carry into minutes");
    expectAt(s + 3599 * TDIV,  3599,  1, 0, "R5 00:59:59");
    expectAt(s + 3600 * TDIV,  3600,  1, 0, "R5 carry into hours");
    expectAt(s + 5025 * TDIV,  5025,  1, 0, "R10 field layout 01:23:45");
    expectAt(s + 35999 * TDIV, 35999, 1, 0, "R6 top value");
    expectAt(s + 36000 * TDIV, 36000, 1, 0, "R6 wrap to zero");
    pulseStart(s);

    t = s + 36001 * TDIV + 1;
    expectAt(t,            36001, 0, 1, "R7 stop sets done");
    expectAt(t + 5 * TDIV, 36001, 0, 1, "R7 total frozen");
    pulseStop(t);

    u = t + 5 * TDIV + 2;
    expectAt(u,            36001, 0, 1, "R8 stop while done ignored");
    expectAt(u + 2 * TDIV, 36001, 0, 1, "R8 done persists");
    pulseStop(u);

    s2 = u + 2 * TDIV + 2;
    s3 = s2 + 2 * TDIV + 1;
    expectAt(s2,            0, 1, 0, "R8 start clears done");
    expectAt(s3 - 1,        2, 1, 0, "R3 second call counting");
    expectAt(s3,            0, 1, 0, "R9 restart mid-call");
    expectAt(s3 + TDIV - 1, 0, 1, 0, "R9 prescaler restarted");
    expectAt(s3 + TDIV,     1, 1, 0, "R9 first second after restart");
    pulseStart(s2);
    pulseStart(s3);

    r = s3 + TDIV + 2;
    expectAt(r,     0, 0, 0, "R1 reset mid-call");
    expectAt(r + 2, 0, 0, 0, "R8 stop while idle ignored");
    while (cyc < r - 1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    pulseStop(r + 2);

    wait (q.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule